// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block chooses whether a protected output rail is fed from the main supply or from a backup battery. It does not sense voltages itself. It receives digital 12-bit codes for three quantities, each with its own valid strobe: the main supply, the battery, and the main-supply trip threshold. From these it produces two outputs. One is a registered source-select signal. The other is a battery-on indicator that drives an external pass transistor.

The rule has two levels. While the main supply is above the trip threshold, the main supply always wins. At or below the threshold, the main supply is compared with the battery using a hysteresis margin. The margin is a programmable code that defaults to 30 LSB, which is 30 mV at 1 mV per LSB. Inside the band between the two switching points, the current choice is kept, so the selection cannot chatter when the two voltages are close.

A decision is taken only in the cycle after a sample strobe. The battery-on output follows the source select one cycle later, so a change of source is always registered before it reaches the external device.

Top module: `bkp_switchover`

## Requirements
- R1: When a decision is taken and the main code is strictly greater than the trip code, `src_batt` becomes 0 (main supply), whatever the battery code.
- R2: When a decision is taken with the main code at or below the trip code and main > battery + margin, `src_batt` becomes 0.
- R3: When a decision is taken with the main code at or below the trip code and main + margin < battery, `src_batt` becomes 1 (battery).
- R4: When a decision is taken with the main code at or below the trip code and battery − margin ≤ main ≤ battery + margin, `src_batt` keeps its value.
- R5: `batt_on` is high when the rail is on the battery and low when it is on the main supply. It equals the value `src_batt` had one cycle earlier.
- R6: A decision is taken only on the clock edge one cycle after an edge where `main_vld`, `batt_vld` or `trip_vld` was high. With no such strobe, or with only a margin write, `src_batt` does not change. A strobe captures its code on the same edge, so the decision uses the newest codes.
- R7: Synchronous active-high `rst` sets `src_batt` and `batt_on` to 0 and restores the margin to 30.
- R8: Until each of the main, battery and trip codes has been strobed at least once since reset, every decision selects the main supply.
- R9: `margin_wr` loads `margin_code` as the new hysteresis margin, and every later decision uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_code | input | 12 | Main supply sample code |
| main_vld | input | 1 | Strobe for main_code |
| batt_code | input | 12 | Battery sample code |
| batt_vld | input | 1 | Strobe for batt_code |
| trip_code | input | 12 | Main-supply trip threshold code |
| trip_vld | input | 1 | Strobe for trip_code |
| margin_code | input | 12 | New hysteresis margin code |
| margin_wr | input | 1 | Loads margin_code |
| src_batt | output | 1 | Source select: 1 = battery, 0 = main supply |
| batt_on | output | 1 | Pass-device drive, src_batt delayed one cycle |

## Verification
Some properties are checked by assertions on every cycle:
- the trip-point priority;
- the hold inside the hysteresis band;
- the main-supply choice before all three codes have been seen;
- the absence of any change without a strobe;
- the one-cycle lag of `batt_on` behind the select;
- the reset values.

Other behaviour can only be shown by the bench scenarios. These cover the exact switching points at battery ± margin, one code either side, and the effect of a newly written margin on later decisions. They also check that the margin returns to its default after a second reset.

// File: rtl/bkp_sw_pkg.sv
package bkp_sw_pkg;

  typedef enum logic [1:0] {
    VERD_HOLD = 2'd0,
    VERD_MAIN = 2'd1,
    VERD_BATT = 2'd2
  } verdict_e;

  localparam int NCH      = 4;
  localparam int CH_MAIN  = 0;
  localparam int CH_BATT  = 1;
  localparam int CH_TRIP  = 2;
  localparam int CH_MARG  = 3;

endpackage

// File: rtl/bkp_sw_capture.sv
module bkp_sw_capture #(
  parameter int W        = 12,
  parameter int RST_VAL  = 0,
  parameter bit SEEN_RST = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         seen
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= RST_VAL[W-1:0];
      seen <= SEEN_RST;
    end else if (wr) begin
      q    <= din;
      seen <= 1'b1;
    end
  end

endmodule

// File: rtl/bkp_sw_decide.sv
module bkp_sw_decide
  import bkp_sw_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         ready,
  input  logic [W-1:0] main_q,
  input  logic [W-1:0] batt_q,
  input  logic [W-1:0] trip_q,
  input  logic [W-1:0] marg_q,
  output verdict_e     verdict
);

  localparam int XW = W + 1;

  logic [XW-1:0] main_x, batt_x, marg_x;
  logic [XW-1:0] batt_hi, main_hi;
  logic          above_trip, main_wins, batt_wins;

  assign main_x  = {1'b0, main_q};
  assign batt_x  = {1'b0, batt_q};
  assign marg_x  = {1'b0, marg_q};
  assign batt_hi = batt_x + marg_x;
  assign main_hi = main_x + marg_x;

  assign above_trip = main_q > trip_q;
  assign main_wins  = main_x > batt_hi;
  assign batt_wins  = main_hi < batt_x;

  always_comb begin
    if (!ready || above_trip || main_wins) verdict = VERD_MAIN;
    else if (batt_wins)                     verdict = VERD_BATT;
    else                                    verdict = VERD_HOLD;
  end

endmodule

// File: rtl/bkp_sw_outreg.sv
module bkp_sw_outreg
  import bkp_sw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     upd,
  input  verdict_e verdict,
  output logic     sel_q,
  output logic     on_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
    end else if (upd) begin
      case (verdict)
        VERD_MAIN: sel_q <= 1'b0;
        VERD_BATT: sel_q <= 1'b1;
        default:   sel_q <= sel_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) on_q <= 1'b0;
    else     on_q <= sel_q;
  end

  AST_ON_LAGS_SEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (on_q == $past(sel_q)));  // R5
  AST_QUIET_NO_UPD: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(sel_q));  // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!sel_q && !on_q));  // R7

endmodule

// File: rtl/bkp_switchover.sv
module bkp_switchover
  import bkp_sw_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int MARGIN_RST = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] main_code,
  input  logic              main_vld,
  input  logic [CODE_W-1:0] batt_code,
  input  logic              batt_vld,
  input  logic [CODE_W-1:0] trip_code,
  input  logic              trip_vld,
  input  logic [CODE_W-1:0] margin_code,
  input  logic              margin_wr,
  output logic              src_batt,
  output logic              batt_on
);

  logic [NCH-1:0][CODE_W-1:0] din_a, q_a;
  logic [NCH-1:0]             wr_a, seen_a;
  logic                       upd_q, ready;
  verdict_e                   verdict;

  assign din_a[CH_MAIN] = main_code;
  assign din_a[CH_BATT] = batt_code;
  assign din_a[CH_TRIP] = trip_code;
  assign din_a[CH_MARG] = margin_code;
  assign wr_a[CH_MAIN]  = main_vld;
  assign wr_a[CH_BATT]  = batt_vld;
  assign wr_a[CH_TRIP]  = trip_vld;
  assign wr_a[CH_MARG]  = margin_wr;

  for (genvar i = 0; i < NCH; i++) begin : g_cap
    bkp_sw_capture #(
      .W        (CODE_W),
      .RST_VAL  ((i == CH_MARG) ? MARGIN_RST : 0),
      .SEEN_RST ((i == CH_MARG) ? 1'b1 : 1'b0)
    ) cap_i (
      .clk  (clk),
      .rst  (rst),
      .wr   (wr_a[i]),
      .din  (din_a[i]),
      .q    (q_a[i]),
      .seen (seen_a[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) upd_q <= 1'b0;
    else     upd_q <= main_vld | batt_vld | trip_vld;
  end

  assign ready = &seen_a;

  bkp_sw_decide #(.W(CODE_W)) decide_i (
    .ready   (ready),
    .main_q  (q_a[CH_MAIN]),
    .batt_q  (q_a[CH_BATT]),
    .trip_q  (q_a[CH_TRIP]),
    .marg_q  (q_a[CH_MARG]),
    .verdict (verdict)
  );

  bkp_sw_outreg outreg_i (
    .clk     (clk),
    .rst     (rst),
    .upd     (upd_q),
    .verdict (verdict),
    .sel_q   (src_batt),
    .on_q    (batt_on)
  );

  AST_TRIP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (upd_q && ready && (q_a[CH_MAIN] > q_a[CH_TRIP])) |=> !src_batt);  // R1
  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (upd_q && ready && (q_a[CH_MAIN] <= q_a[CH_TRIP]) &&
     ({1'b0, q_a[CH_MAIN]} <= {1'b0, q_a[CH_BATT]} + {1'b0, q_a[CH_MARG]}) &&
     ({1'b0, q_a[CH_MAIN]} + {1'b0, q_a[CH_MARG]} >= {1'b0, q_a[CH_BATT]}))
    |=> $stable(src_batt));  // R4
  AST_NOT_READY_MAIN: assert property (@(posedge clk) disable iff (rst)
    (upd_q && !ready) |=> !src_batt);  // R8

endmodule

// File: tb/bkp_switchover_tb_top.sv
module bkp_switchover_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] main_code, batt_code, trip_code, margin_code;
  logic        main_vld, batt_vld, trip_vld, margin_wr;
  logic        src_batt, batt_on;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bkp_switchover dut_i (
    .clk(clk), .rst(rst),
    .main_code(main_code), .main_vld(main_vld),
    .batt_code(batt_code), .batt_vld(batt_vld),
    .trip_code(trip_code), .trip_vld(trip_vld),
    .margin_code(margin_code), .margin_wr(margin_wr),
    .src_batt(src_batt), .batt_on(batt_on)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one strobe cycle; returns at the negedge after the capturing edge
  task automatic drive(input bit mv, input int m, input bit bv, input int b,
                       input bit tv, input int t, input bit hw, input int h);
    @(negedge clk);
    if (mv) main_code   = 12'(m);
    if (bv) batt_code   = 12'(b);
    if (tv) trip_code   = 12'(t);
    if (hw) margin_code = 12'(h);
    main_vld = mv; batt_vld = bv; trip_vld = tv; margin_wr = hw;
    @(negedge clk);
    main_vld = 1'b0; batt_vld = 1'b0; trip_vld = 1'b0; margin_wr = 1'b0;
  endtask

  task automatic apply(input int m, input int b, input int t);
    drive(1, m, 1, b, 1, t, 0, 0);
    wait_n(3);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    wait_n(2); rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R7 src after reset", src_batt, 1'b0);
    chk("R7 batt_on after reset", batt_on, 1'b0);
  endtask

  task automatic t_not_ready();
    drive(1, 100, 1, 3000, 0, 0, 0, 0); wait_n(3);
    chk("R8 no trip seen yet", src_batt, 1'b0);
    drive(0, 0, 0, 0, 1, 2000, 0, 0); wait_n(3);
    chk("R3 battery once ready", src_batt, 1'b1);
  endtask

  task automatic t_trip_priority();
    apply(3000, 3500, 2800);
    chk("R1 above trip forces main", src_batt, 1'b0);
    chk("R5 batt_on low on main", batt_on, 1'b0);
  endtask

  task automatic t_compare();
    apply(1000, 3000, 2800);
    chk("R3 main far below battery", src_batt, 1'b1);
    chk("R5 batt_on high on battery", batt_on, 1'b1);
    apply(2500, 2000, 2800);
    chk("R2 main above battery+margin", src_batt, 1'b0);
  endtask

  task automatic t_band();
    apply(1000, 3000, 4000);
    apply(3030, 3000, 4000);
    chk("R4 main=batt+margin holds battery", src_batt, 1'b1);
    apply(3031, 3000, 4000);
    chk("R2 one above upper point", src_batt, 1'b0);
    apply(2970, 3000, 4000);
    chk("R4 main=batt-margin holds main", src_batt, 1'b0);
    apply(2969, 3000, 4000);
    chk("R3 one below lower point", src_batt, 1'b1);
  endtask

  task automatic t_delay();
    drive(1, 3100, 1, 3000, 1, 4000, 0, 0);
    @(negedge clk);
    chk("R5 select moved first", src_batt, 1'b0);
    chk("R5 batt_on still old", batt_on, 1'b1);
    @(negedge clk);
    chk("R5 batt_on one cycle later", batt_on, 1'b0);
  endtask

  task automatic t_no_strobe_and_margin();
    @(negedge clk); main_code = 12'd100; wait_n(4);
    chk("R6 unstrobed code ignored", src_batt, 1'b0);
    drive(0, 0, 0, 0, 0, 0, 1, 500); wait_n(3);
    chk("R6 margin write alone no decision", src_batt, 1'b0);
    apply(2600, 3000, 4000);
    chk("R9 wide margin holds main", src_batt, 1'b0);
    apply(2499, 3000, 4000);
    chk("R9 below wide margin switches", src_batt, 1'b1);
  endtask

  task automatic t_reset_again();
    do_reset();
    chk("R7 src after second reset", src_batt, 1'b0);
    chk("R7 batt_on after second reset", batt_on, 1'b0);
    apply(2969, 3000, 4000);
    chk("R7 margin back to 30", src_batt, 1'b1);
  endtask

  initial begin
    rst = 1'b1;
    main_code = '0; batt_code = '0; trip_code = '0; margin_code = '0;
    main_vld = 1'b0; batt_vld = 1'b0; trip_vld = 1'b0; margin_wr = 1'b0;
    wait_n(3); rst = 1'b0; @(negedge clk);
    t_reset();
    t_not_ready();
    t_trip_priority();
    t_compare();
    t_band();
    t_delay();
    t_no_strobe_and_margin();
    t_reset_again();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule